// File: doc/BRIEF.md
# Receive Queue with Mode-Selected Trigger and Flow-Control Levels

This block buffers received bytes between a serial receiver and its consumer. It reports how full it is and raises a data-ready interrupt request once the fill reaches an upper trigger level. It also drives a flow-control hold signal that applies hysteresis: the hold is raised at the upper level and dropped only when the fill has fallen to a lower level.

Both levels and the usable depth come from a compatibility mode and a 2-bit trigger select. The five modes are:
- a single-byte holding register,
- a 16-entry queue,
- an extended 128-entry queue,
- an alternate 128-entry queue with its own level pairs,
- a programmable 128-entry mode, where the levels come from two input buses.

The push side carries `in_valid` and `in_data` and has no ready signal, because a serial receiver cannot be stalled. A byte offered while the queue is full is discarded and latches the overrun flag. The pop side is valid/ready: `out_data` is the oldest entry whenever `out_valid` is high, and a byte leaves on a clock edge where both `out_valid` and `out_ready` are high. Raising `out_ready` while `out_valid` is low removes nothing. `fifo_clr` empties the queue synchronously. Software should pulse `fifo_clr` after it changes the mode.

Top module: `rxq_thresh_fifo`

## Requirements
- R1: After reset, or on the clock edge after `fifo_clr` is sampled high, `fill_level` is 0, `out_valid` is 0, `flow_hold` is 0 and `overrun` is 0. `fifo_clr` takes priority over a push or pop in the same cycle.
- R2: Bytes leave in the order they were accepted. One clock edge after a push or pop, `fill_level` equals accepted pushes minus completed pops. A push and a pop on the same edge leave the level unchanged.
- R3: The usable depth follows `mode`: code 0 (byte) gives 1 entry, code 1 gives 16, codes 2, 3 and 4 give 128. `fill_level` never exceeds the depth.
- R4: A push while `fill_level` equals the depth is dropped, even when a pop completes on the same edge. The drop sets `overrun`, which stays set until `fifo_clr` or reset.
- R5: Asserting `out_ready` while the queue is empty has no effect: `fill_level` stays 0.
- R6: The upper level is selected by `trig_sel` = 0/1/2/3, as follows. Code 1: 1, 4, 8, 14. Code 2: 1, 32, 64, 112. Code 3: 16, 32, 112, 120. Code 0: always 1. Code 4: `prog_upper` with `trig_sel` ignored, where a value of 0 acts as 1.
- R7: `rx_irq` is high exactly when `irq_en` is high and `fill_level` is at or above the upper level.
- R8: The lower level is selected as follows. Code 2: always 1. Code 3 with `trig_sel` = 0/1/2/3: 1, 16, 32, 112. Code 0: 1. Code 4: `prog_lower`.
- R9: `flow_hold` becomes 1 on the edge where the fill reaches the upper level or more. It becomes 0 when the fill is below the upper level and at or below the lower level. Otherwise it keeps its value. In mode code 1 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous queue clear |
| mode | input | 3 | Compatibility mode code (0 byte, 1 16-deep, 2 extended, 3 alternate, 4 programmable) |
| trig_sel | input | 2 | Trigger select for the level tables |
| prog_upper | input | 8 | Upper level in programmable mode |
| prog_lower | input | 8 | Lower level in programmable mode |
| irq_en | input | 1 | Data-ready interrupt enable |
| in_valid | input | 1 | Push strobe |
| in_data | input | 8 | Pushed byte |
| out_valid | output | 1 | Queue holds at least one byte |
| out_ready | input | 1 | Consumer accepts the head byte |
| out_data | output | 8 | Oldest byte in the queue |
| fill_level | output | 8 | Number of bytes held |
| rx_irq | output | 1 | Data-ready interrupt request |
| flow_hold | output | 1 | Flow-control hold with hysteresis |
| overrun | output | 1 | Sticky push-dropped flag |

## Verification
A push and a pop can land on the same edge. This matters most when the queue is full: the pop completes but the push is still dropped and flags overrun. The bench fills the 16-entry mode to the brim and then drives both strobes together. It expects the level to fall by one, the head byte to be the oldest, and `overrun` to rise. At a mid level, a simultaneous push and pop in the extended mode must leave the level and the hold unchanged.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [2:0] {
    RXQ_BYTE = 3'd0,
    RXQ_D16  = 3'd1,
    RXQ_X128 = 3'd2,
    RXQ_A128 = 3'd3,
    RXQ_PROG = 3'd4
  } rxq_mode_e;
endpackage

// File: rtl/rxq_level_lut.sv
module rxq_level_lut
  import rxq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SMALL_DEPTH = 16,
  parameter int LARGE_DEPTH = 128
) (
  input  logic [2:0]       mode,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] prog_upper,
  input  logic [CNT_W-1:0] prog_lower,
  output logic [CNT_W-1:0] upper,
  output logic [CNT_W-1:0] lower,
  output logic [CNT_W-1:0] depth,
  output logic             flow_en
);
  rxq_mode_e m;
  assign m = rxq_mode_e'(mode);

  always_comb begin
    upper   = CNT_W'(1);
    lower   = CNT_W'(1);
    depth   = CNT_W'(1);
    flow_en = 1'b1;
    case (m)
      RXQ_D16: begin
        depth   = CNT_W'(SMALL_DEPTH);
        flow_en = 1'b0;
        case (trig_sel)
          2'd0: upper = CNT_W'(1);
          2'd1: upper = CNT_W'(4);
          2'd2: upper = CNT_W'(8);
          default: upper = CNT_W'(14);
        endcase
        lower = upper;
      end
      RXQ_X128: begin
        depth = CNT_W'(LARGE_DEPTH);
        case (trig_sel)
          2'd0: upper = CNT_W'(1);
          2'd1: upper = CNT_W'(32);
          2'd2: upper = CNT_W'(64);
          default: upper = CNT_W'(112);
        endcase
      end
      RXQ_A128: begin
        depth = CNT_W'(LARGE_DEPTH);
        case (trig_sel)
          2'd0: begin upper = CNT_W'(16);  lower = CNT_W'(1);   end
          2'd1: begin upper = CNT_W'(32);  lower = CNT_W'(16);  end
          2'd2: begin upper = CNT_W'(112); lower = CNT_W'(32);  end
          default: begin upper = CNT_W'(120); lower = CNT_W'(112); end
        endcase
      end
      RXQ_PROG: begin
        depth = CNT_W'(LARGE_DEPTH);
        upper = (prog_upper == '0) ? CNT_W'(1) : prog_upper;
        lower = prog_lower;
      end
      default: begin
        upper = CNT_W'(1);
        lower = CNT_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W    = 8,
  parameter int DEPTH_MAX = 128,
  parameter int CNT_W     = 8,
  parameter int PTR_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CNT_W-1:0]  depth,
  input  logic              push_v,
  input  logic [DATA_W-1:0] push_d,
  input  logic              pop_rdy,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_next,
  output logic              overrun
);
  logic [DATA_W-1:0] mem [DEPTH_MAX];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              full, push_ok, pop_ok;

  assign full      = (count >= depth);
  assign out_valid = (count != '0);
  assign push_ok   = push_v && !full && !clr;
  assign pop_ok    = pop_rdy && out_valid && !clr;
  assign out_data  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [CNT_W-1:0] d);
    if (CNT_W'(p) + CNT_W'(1) >= d) return '0;
    return p + PTR_W'(1);
  endfunction

  always_comb begin
    if (clr) count_next = '0;
    else     count_next = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else if (clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      count <= count_next;
      if (push_ok) wr_ptr <= bump(wr_ptr, depth);
      if (pop_ok)  rd_ptr <= bump(rd_ptr, depth);
      if (push_v && full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] count_next,
  input  logic [CNT_W-1:0] upper,
  input  logic [CNT_W-1:0] lower,
  input  logic             flow_en,
  input  logic             irq_en,
  output logic             hold,
  output logic             irq
);
  logic hold_d;

  always_comb begin
    hold_d = hold;
    if (clr || !flow_en)           hold_d = 1'b0;
    else if (count_next >= upper)  hold_d = 1'b1;
    else if (count_next <= lower)  hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= 1'b0;
    else        hold <= hold_d;
  end

  assign irq = irq_en && (count >= upper);
endmodule

// File: rtl/rxq_thresh_fifo.sv
module rxq_thresh_fifo #(
  parameter int DATA_W      = 8,
  parameter int SMALL_DEPTH = 16,
  parameter int LARGE_DEPTH = 128,
  localparam int CNT_W      = $clog2(LARGE_DEPTH + 1),
  localparam int PTR_W      = $clog2(LARGE_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_clr,
  input  logic [2:0]        mode,
  input  logic [1:0]        trig_sel,
  input  logic [CNT_W-1:0]  prog_upper,
  input  logic [CNT_W-1:0]  prog_lower,
  input  logic              irq_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  fill_level,
  output logic              rx_irq,
  output logic              flow_hold,
  output logic              overrun
);
  logic [CNT_W-1:0] upper_lvl, lower_lvl, depth_eff, count_next;
  logic             flow_en;

  rxq_level_lut #(
    .CNT_W(CNT_W), .SMALL_DEPTH(SMALL_DEPTH), .LARGE_DEPTH(LARGE_DEPTH)
  ) lut_i (
    .mode(mode), .trig_sel(trig_sel),
    .prog_upper(prog_upper), .prog_lower(prog_lower),
    .upper(upper_lvl), .lower(lower_lvl), .depth(depth_eff), .flow_en(flow_en)
  );

  rxq_store #(
    .DATA_W(DATA_W), .DEPTH_MAX(LARGE_DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .depth(depth_eff),
    .push_v(in_valid), .push_d(in_data), .pop_rdy(out_ready),
    .out_valid(out_valid), .out_data(out_data),
    .count(fill_level), .count_next(count_next), .overrun(overrun)
  );

  rxq_flow #(.CNT_W(CNT_W)) flow_i (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .count(fill_level), .count_next(count_next),
    .upper(upper_lvl), .lower(lower_lvl), .flow_en(flow_en), .irq_en(irq_en),
    .hold(flow_hold), .irq(rx_irq)
  );
endmodule

// File: rtl/rxq_thresh_fifo_chk.sv
module rxq_thresh_fifo_chk #(
  parameter int CNT_W       = 8,
  parameter int LARGE_DEPTH = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_clr,
  input logic [2:0]       mode,
  input logic             irq_en,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CNT_W-1:0] fill_level,
  input logic [CNT_W-1:0] depth_eff,
  input logic             rx_irq,
  input logic             flow_hold,
  input logic             overrun
);
  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fill_level == '0 && !flow_hold && !overrun));

  a_r2_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_clr |=> (int'(fill_level) <= int'($past(fill_level)) + 1 &&
                   int'(fill_level) + 1 >= int'($past(fill_level))));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_level) <= LARGE_DEPTH);

  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill_level >= depth_eff && !fifo_clr) |=> overrun);

  a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !fifo_clr) |=> overrun);

  a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0 && !in_valid && out_ready) |=> fill_level == '0);

  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !rx_irq);

  a_r9_d16_no_flow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |=> !flow_hold);

  a_r2_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (fill_level != '0));
endmodule

bind rxq_thresh_fifo rxq_thresh_fifo_chk #(
  .CNT_W(CNT_W), .LARGE_DEPTH(LARGE_DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .mode(mode), .irq_en(irq_en),
  .in_valid(in_valid), .out_valid(out_valid), .out_ready(out_ready),
  .fill_level(fill_level), .depth_eff(depth_eff), .rx_irq(rx_irq),
  .flow_hold(flow_hold), .overrun(overrun)
);

// File: tb/rxq_thresh_fifo_tb.sv
`timescale 1ns/1ps
module rxq_thresh_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_clr = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [1:0] trig_sel = 2'd0;
  logic [7:0] prog_upper = 8'd0, prog_lower = 8'd0;
  logic       irq_en = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       out_valid, out_ready = 1'b0;
  logic [7:0] out_data, fill_level;
  logic       rx_irq, flow_hold, overrun;

  int checks = 0, failures = 0;
  logic [7:0] mq[$];
  bit mhold = 0, movr = 0;

  always #10 clk = ~clk;

  rxq_thresh_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .mode(mode),
    .trig_sel(trig_sel), .prog_upper(prog_upper), .prog_lower(prog_lower),
    .irq_en(irq_en), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fill_level(fill_level), .rx_irq(rx_irq), .flow_hold(flow_hold),
    .overrun(overrun)
  );

  function automatic int e_depth(input int m);
    if (m == 1) return 16;
    if (m >= 2 && m <= 4) return 128;
    return 1;
  endfunction

  function automatic int e_upper(input int m, input int s, input int pu);
    case (m)
      1: return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      2: return (s == 0) ? 1 : (s == 1) ? 32 : (s == 2) ? 64 : 112;
      3: return (s == 0) ? 16 : (s == 1) ? 32 : (s == 2) ? 112 : 120;
      4: return (pu == 0) ? 1 : pu;
      default: return 1;
    endcase
  endfunction

  function automatic int e_lower(input int m, input int s, input int pl);
    case (m)
      3: return (s == 0) ? 1 : (s == 1) ? 16 : (s == 2) ? 32 : 112;
      4: return pl;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    int m = int'(mode);
    int up = e_upper(m, int'(trig_sel), int'(prog_upper));
    int cnt = mq.size();
    chk(int'(fill_level) == cnt, "R2 fill", int'(fill_level), cnt);
    chk(int'(fill_level) <= e_depth(m), "R3 depth", int'(fill_level), e_depth(m));
    chk(out_valid == (cnt > 0), "R2 out_valid", int'(out_valid), int'(cnt > 0));
    chk(rx_irq == (irq_en && cnt >= up), "R6 R7 irq", int'(rx_irq),
        int'(irq_en && cnt >= up));
    chk(flow_hold == mhold, "R8 R9 hold", int'(flow_hold), int'(mhold));
    chk(overrun == movr, "R4 overrun", int'(overrun), int'(movr));
  endtask

  task automatic step(input bit pv, input logic [7:0] pd, input bit pr);
    int m = int'(mode);
    int dep = e_depth(m);
    int cnt = mq.size();
    bit pop_ok = pr && cnt > 0;
    bit push_ok = pv && cnt < dep;
    int up = e_upper(m, int'(trig_sel), int'(prog_upper));
    int lo = e_lower(m, int'(trig_sel), int'(prog_lower));
    if (pop_ok) chk(out_data == mq[0], "R2 order", int'(out_data), int'(mq[0]));
    in_valid = pv; in_data = pd; out_ready = pr;
    @(posedge clk);
    if (pop_ok) void'(mq.pop_front());
    if (push_ok) mq.push_back(pd);
    if (pv && !push_ok) movr = 1;
    cnt = mq.size();
    if (m == 1) mhold = 0;
    else if (cnt >= up) mhold = 1;
    else if (cnt <= lo) mhold = 0;
    @(negedge clk);
    in_valid = 0; out_ready = 0;
    check_outputs();
    if (pr && !pv && cnt == 0) chk(fill_level == 0, "R5 empty pop", int'(fill_level), 0);
  endtask

  task automatic clear_q();
    fifo_clr = 1; in_valid = 1; in_data = 8'hEE; out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    fifo_clr = 0; in_valid = 0; out_ready = 0;
    mq.delete(); mhold = 0; movr = 0;
    chk(fill_level == 0 && !out_valid && !flow_hold && !overrun, "R1 clear",
        int'(fill_level), 0);
  endtask

  task automatic sweep(input int m, input int s, input int pu, input int pl);
    int dep;
    mode = 3'(m); trig_sel = 2'(s);
    prog_upper = 8'(pu); prog_lower = 8'(pl);
    clear_q();
    dep = e_depth(m);
    for (int i = 0; i < dep + 2; i++) step(1, 8'(i * 7 + m * 31 + s), 0);
    for (int i = 0; i < dep + 2; i++) step(0, 8'h00, 1);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fill_level == 0 && !out_valid && !flow_hold && !overrun && !rx_irq,
        "R1 reset", int'(fill_level), 0);
    rst_n = 1;
    @(negedge clk);
    // full sweep of fixed modes, every trigger select
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++) sweep(m, s, 0, 0);
    // programmable mode: trig_sel varied but ignored
    sweep(4, 0, 5, 2);
    sweep(4, 1, 40, 40);
    sweep(4, 2, 0, 3);
    sweep(4, 3, 100, 20);
    // R7 interrupt disabled
    irq_en = 0;
    sweep(1, 2, 0, 0);
    irq_en = 1;
    // R4 push and pop on the same edge while full
    mode = 3'd1; trig_sel = 2'd0;
    clear_q();
    for (int i = 0; i < 16; i++) step(1, 8'(100 + i), 0);
    step(1, 8'hAB, 1);
    chk(int'(fill_level) == 15 && overrun, "R4 collision", int'(fill_level), 15);
    // R2 push and pop together at mid level in extended mode
    mode = 3'd2; trig_sel = 2'd1;
    clear_q();
    for (int i = 0; i < 40; i++) step(1, 8'(i), 0);
    for (int i = 0; i < 5; i++) step(1, 8'(200 + i), 1);
    chk(int'(fill_level) == 40 && flow_hold, "R2 R9 mid level", int'(fill_level), 40);
    // R9 hysteresis band in alternate mode, sel 1 (upper 32, lower 16)
    mode = 3'd3;
    clear_q();
    for (int i = 0; i < 32; i++) step(1, 8'(i), 0);
    for (int i = 0; i < 10; i++) step(0, 8'h00, 1);
    chk(flow_hold == 1, "R9 band hold", int'(flow_hold), 1);
    for (int i = 0; i < 6; i++) step(0, 8'h00, 1);
    chk(flow_hold == 0, "R8 release at lower", int'(flow_hold), 0);
    // R1 clear while holding data and overrun
    for (int i = 0; i < 130; i++) step(1, 8'(i), 0);
    clear_q();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule